// File: doc/BRIEF.md
# Dual-Issue Register Hazard Resolver

This block decides how one issued instruction pair shares registers between its two slots. Each pair has an upper slot and a lower slot, and the upper slot is treated as executing first. The resolver takes both slots' decoded register indices and a few clip-flag access bits. It then returns one registered set of controls, aligned to the issue stage of the following cycle.

The controls tell the lower slot three things: whether each vector operand must come from a copy saved before the upper write, whether the clip-flag read must use the saved copy, and whether its results are dropped. An immediate-carrying pair has no lower operation, so no hazard is evaluated for it. Vector register index zero stands for "no register" and never takes part in a hazard.

Top module: `dual_issue_hazard`

## Requirements
- R1: All outputs are registered one clock after the inputs they depend on, and `q_valid` follows `issue_valid` by exactly one cycle. During and right after reset every output is 0.
- R2: Operand select bit i of `q_src_old` is 1 when all of the following hold for the pair: it is valid, it carries no immediate, it is not discarded, `up_vf_wr` is nonzero, and lower read index i equals `up_vf_wr`. Lower read index i is the field `lo_vf_rd[i*IDX_W +: IDX_W]`. The bit is 0 in every other case.
- R3: `q_lo_en` is 1 exactly when the pair is valid, carries no immediate and is not discarded. The lower slot commits its results only then, so after a colliding pair the upper slot's write is the one that remains.
- R4: A valid, non-immediate pair where `up_vf_wr` is nonzero and equals `lo_vf_wr` raises `q_discard`.
- R5: `q_flag_old` is 1 when a valid, non-immediate, non-discarded pair has both `up_flag_rd` and `lo_flag_rd` set.
- R6: A valid, non-immediate pair with `up_flag_rd` and `lo_flag_wr` both set raises `q_discard`.
- R7: When `imm_flag` is set on a valid pair, `q_lo_en`, `q_discard`, `q_src_old` and `q_flag_old` are all 0, whatever the other inputs are.
- R8: A zero `up_vf_wr` never raises `q_discard` and never sets a `q_src_old` bit, even when lower indices are also zero.
- R9: When `issue_valid` is 0, every control output is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An instruction pair is presented |
| imm_flag | input | 1 | Pair carries an immediate, no lower operation |
| up_vf_wr | input | IDX_W | Upper slot vector write index, 0 = none |
| lo_vf_wr | input | IDX_W | Lower slot vector write index, 0 = none |
| lo_vf_rd | input | NSRC*IDX_W | Lower slot vector read indices, source i at bits i*IDX_W |
| up_flag_rd | input | 1 | Upper slot reads the clip flag |
| lo_flag_rd | input | 1 | Lower slot reads the clip flag |
| lo_flag_wr | input | 1 | Lower slot writes the clip flag |
| q_valid | output | 1 | Registered pair valid |
| q_lo_en | output | 1 | Lower slot executes and commits |
| q_discard | output | 1 | Lower slot results are dropped |
| q_src_old | output | NSRC | Per-source select of the pre-upper-write value |
| q_flag_old | output | 1 | Clip-flag read uses the pre-upper value |

## Verification
The bench targets these cases:
- A write-write collision that also has a read match. A design that ordered these checks wrongly would assert an old-value select on a discarded pair.
- Both slots on index zero. A naive comparator would report a collision here.
- An immediate pair whose indices all collide. Skipping the immediate gate would leak discards or selects.
- A flag-read/flag-write pair. A design that missed this case would let the lower slot commit.

Random pairs over a small index range then hit every combination many times. Idle cycles in between expose any output that fails to clear.

// File: rtl/dih_pkg.sv
package dih_pkg;
  typedef struct packed {
    logic valid;
    logic lo_en;
    logic discard;
    logic flag_old;
  } dih_ctl_t;
endpackage

// File: rtl/dih_vf_match.sv
module dih_vf_match #(
  parameter int IDX_W = 5,
  parameter int NSRC  = 2
) (
  input  logic [IDX_W-1:0]      wr_up,
  input  logic [IDX_W-1:0]      wr_lo,
  input  logic [NSRC*IDX_W-1:0] rd_lo,
  output logic                  ww_hit,
  output logic [NSRC-1:0]       rd_hit
);
  logic up_live;

  assign up_live = |wr_up;
  assign ww_hit  = up_live && (wr_up == wr_lo);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign rd_hit[i] = up_live && (rd_lo[i*IDX_W +: IDX_W] == wr_up);
  end
endmodule

// File: rtl/dih_flag_match.sv
module dih_flag_match (
  input  logic up_rd,
  input  logic lo_rd,
  input  logic lo_wr,
  output logic rw_hit,
  output logic rr_hit
);
  assign rw_hit = up_rd && lo_wr;
  assign rr_hit = up_rd && lo_rd;
endmodule

// File: rtl/dual_issue_hazard.sv
module dual_issue_hazard #(
  parameter int IDX_W = 5,
  parameter int NSRC  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  issue_valid,
  input  logic                  imm_flag,
  input  logic [IDX_W-1:0]      up_vf_wr,
  input  logic [IDX_W-1:0]      lo_vf_wr,
  input  logic [NSRC*IDX_W-1:0] lo_vf_rd,
  input  logic                  up_flag_rd,
  input  logic                  lo_flag_rd,
  input  logic                  lo_flag_wr,
  output logic                  q_valid,
  output logic                  q_lo_en,
  output logic                  q_discard,
  output logic [NSRC-1:0]       q_src_old,
  output logic                  q_flag_old
);
  import dih_pkg::*;

  logic            vf_ww, fl_rw, fl_rr;
  logic [NSRC-1:0] vf_rd;
  logic            checked, drop;
  dih_ctl_t        ctl_d, ctl_q;
  logic [NSRC-1:0] src_d, src_q;
  logic            ld_en;

  dih_vf_match #(.IDX_W(IDX_W), .NSRC(NSRC)) u_vf (
    .wr_up  (up_vf_wr),
    .wr_lo  (lo_vf_wr),
    .rd_lo  (lo_vf_rd),
    .ww_hit (vf_ww),
    .rd_hit (vf_rd)
  );

  dih_flag_match u_fl (
    .up_rd  (up_flag_rd),
    .lo_rd  (lo_flag_rd),
    .lo_wr  (lo_flag_wr),
    .rw_hit (fl_rw),
    .rr_hit (fl_rr)
  );

  // Next-state: hazards only count for a valid pair without immediate.
  always_comb begin
    checked          = issue_valid && !imm_flag;
    drop             = checked && (vf_ww || fl_rw);
    ctl_d.valid      = issue_valid;
    ctl_d.discard    = drop;
    ctl_d.lo_en      = checked && !drop;
    ctl_d.flag_old   = checked && !drop && fl_rr;
    src_d            = (checked && !drop) ? vf_rd : '0;
  end

  assign ld_en = issue_valid || ctl_q.valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      src_q <= '0;
    end else if (ld_en) begin
      ctl_q <= ctl_d;
      src_q <= src_d;
    end
  end

  assign q_valid    = ctl_q.valid;
  assign q_lo_en    = ctl_q.lo_en;
  assign q_discard  = ctl_q.discard;
  assign q_flag_old = ctl_q.flag_old;
  assign q_src_old  = src_q;
endmodule

// File: rtl/dual_issue_hazard_chk.sv
module dual_issue_hazard_chk #(
  parameter int IDX_W = 5,
  parameter int NSRC  = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  issue_valid,
  input logic                  imm_flag,
  input logic [IDX_W-1:0]      up_vf_wr,
  input logic [IDX_W-1:0]      lo_vf_wr,
  input logic                  up_flag_rd,
  input logic                  lo_flag_wr,
  input logic                  q_valid,
  input logic                  q_lo_en,
  input logic                  q_discard,
  input logic [NSRC-1:0]       q_src_old,
  input logic                  q_flag_old
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> q_valid); // R1
  AST_EN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    q_lo_en |-> !q_discard); // R3
  AST_WW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !imm_flag && (up_vf_wr != '0) && (up_vf_wr == lo_vf_wr)) |=> q_discard); // R4
  AST_FLAG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !imm_flag && up_flag_rd && lo_flag_wr) |=> q_discard); // R6
  AST_IMM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && imm_flag) |=> (!q_lo_en && !q_discard && !q_flag_old && (q_src_old == '0))); // R7
  AST_ZERO_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && (up_vf_wr == '0) && !(up_flag_rd && lo_flag_wr)) |=> (!q_discard && (q_src_old == '0))); // R8
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> (!q_valid && !q_lo_en && !q_discard && !q_flag_old && (q_src_old == '0))); // R9
endmodule

bind dual_issue_hazard dual_issue_hazard_chk #(.IDX_W(IDX_W), .NSRC(NSRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .imm_flag    (imm_flag),
  .up_vf_wr    (up_vf_wr),
  .lo_vf_wr    (lo_vf_wr),
  .up_flag_rd  (up_flag_rd),
  .lo_flag_wr  (lo_flag_wr),
  .q_valid     (q_valid),
  .q_lo_en     (q_lo_en),
  .q_discard   (q_discard),
  .q_src_old   (q_src_old),
  .q_flag_old  (q_flag_old)
);

// File: tb/dual_issue_hazard_tb.sv
module dual_issue_hazard_tb;
  localparam int IDX_W = 5;
  localparam int NSRC  = 2;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic issue_valid, imm_flag, up_flag_rd, lo_flag_rd, lo_flag_wr;
  logic [IDX_W-1:0] up_vf_wr, lo_vf_wr;
  logic [NSRC*IDX_W-1:0] lo_vf_rd;
  logic q_valid, q_lo_en, q_discard, q_flag_old;
  logic [NSRC-1:0] q_src_old;

  int n_vec = 0;
  int n_bad = 0;

  // expected outputs for the next comparison
  int e_valid, e_en, e_disc, e_flag, e_src;
  int e_imm;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_issue_hazard #(.IDX_W(IDX_W), .NSRC(NSRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .imm_flag(imm_flag),
    .up_vf_wr(up_vf_wr), .lo_vf_wr(lo_vf_wr), .lo_vf_rd(lo_vf_rd),
    .up_flag_rd(up_flag_rd), .lo_flag_rd(lo_flag_rd), .lo_flag_wr(lo_flag_wr),
    .q_valid(q_valid), .q_lo_en(q_lo_en), .q_discard(q_discard),
    .q_src_old(q_src_old), .q_flag_old(q_flag_old)
  );

  task automatic chk(input string tag, input string nm, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, got, exp);
    end
  endtask

  // Behavioural model of the requirements, evaluated on the driven inputs.
  task automatic predict();
    int uw, lw, live, drop, r;
    uw = int'(up_vf_wr);
    lw = int'(lo_vf_wr);
    live = (issue_valid && !imm_flag) ? 1 : 0;
    drop = 0;
    if (live && uw != 0 && uw == lw) drop = 1;
    if (live && up_flag_rd && lo_flag_wr) drop = 1;
    e_valid = issue_valid ? 1 : 0;
    e_imm   = (issue_valid && imm_flag) ? 1 : 0;
    e_disc  = drop;
    e_en    = (live && !drop) ? 1 : 0;
    e_flag  = (live && !drop && up_flag_rd && lo_flag_rd) ? 1 : 0;
    e_src   = 0;
    for (int i = 0; i < NSRC; i++) begin
      r = int'(lo_vf_rd[i*IDX_W +: IDX_W]);
      if (live && !drop && uw != 0 && r == uw) e_src |= (1 << i);
    end
  endtask

  task automatic compare_all();
    string t_en, t_disc, t_src, t_flag;
    t_en = "R3"; t_disc = "R4/R6"; t_src = "R2"; t_flag = "R5";
    if (!e_valid) begin t_en = "R9"; t_disc = "R9"; t_src = "R9"; t_flag = "R9"; end
    else if (e_imm) begin t_en = "R7"; t_disc = "R7"; t_src = "R7"; t_flag = "R7"; end
    chk("R1", "q_valid", int'(q_valid), e_valid);
    chk(t_en, "q_lo_en", int'(q_lo_en), e_en);
    chk(t_disc, "q_discard", int'(q_discard), e_disc);
    chk(t_src, "q_src_old", int'(q_src_old), e_src);
    chk(t_flag, "q_flag_old", int'(q_flag_old), e_flag);
  endtask

  // Drive at negedge, compare one clock later at the following negedge.
  task automatic apply(input logic v, input logic im, input int uw, input int lw,
                       input int r0, input int r1, input logic ufr,
                       input logic lfr, input logic lfw);
    issue_valid = v; imm_flag = im;
    up_vf_wr = IDX_W'(uw); lo_vf_wr = IDX_W'(lw);
    lo_vf_rd = {IDX_W'(r1), IDX_W'(r0)};
    up_flag_rd = ufr; lo_flag_rd = lfr; lo_flag_wr = lfw;
    predict();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    issue_valid = 0; imm_flag = 0; up_vf_wr = '0; lo_vf_wr = '0; lo_vf_rd = '0;
    up_flag_rd = 0; lo_flag_rd = 0; lo_flag_wr = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset q_valid", int'(q_valid), 0);
    chk("R1", "reset q_lo_en", int'(q_lo_en), 0);
    chk("R1", "reset q_discard", int'(q_discard), 0);
    chk("R1", "reset q_src_old", int'(q_src_old), 0);
    rst_n = 1'b1;
    @(negedge clk);

    apply(1, 0, 3, 7, 3, 5, 0, 0, 0);  // R2 source 0 old
    apply(1, 0, 4, 0, 4, 4, 0, 0, 0);  // R2 both sources old
    apply(1, 0, 6, 6, 6, 1, 0, 0, 0);  // R4 collision overrides read match
    apply(1, 0, 0, 0, 0, 0, 0, 0, 0);  // R8 all zero indices
    chk("R8", "zero idx discard", int'(q_discard), 0);
    chk("R8", "zero idx src", int'(q_src_old), 0);
    apply(1, 0, 2, 9, 1, 1, 1, 1, 0);  // R5 flag old
    apply(1, 0, 2, 9, 2, 1, 1, 0, 1);  // R6 flag read/write drop
    apply(1, 1, 5, 5, 5, 5, 1, 1, 1);  // R7 immediate ignores everything
    chk("R7", "imm discard", int'(q_discard), 0);
    apply(0, 0, 5, 5, 5, 5, 1, 1, 1);  // R9 idle
    chk("R9", "idle discard", int'(q_discard), 0);
    apply(1, 0, 8, 3, 1, 2, 0, 1, 1);  // R3 lower commits

    for (int k = 0; k < 3000; k++) begin
      apply(($urandom % 5) != 0, ($urandom % 6) == 0,
            int'($urandom % 4), int'($urandom % 4),
            int'($urandom % 4), int'($urandom % 4),
            ($urandom % 2) == 1, ($urandom % 2) == 1, ($urandom % 3) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule